// File: doc/BRIEF.md
# Address-Latched One-Hot Decoder

This block turns a three-bit address into eight active-low select lines, of which at most one is driven low. A hold stage sits in front of the decode. While the hold control is low, the stage passes the live address straight through in the same cycle. When the hold control goes high, the address present in that cycle is captured. From then on the decode uses the captured value, and the address pins are ignored until the hold control drops again.

Two output enables of opposite polarity gate the select lines, one active high and one active low. They act on the final output stage only. Disabling the outputs forces every line high at once and leaves the captured address untouched, so re-enabling brings back the same selection.

The hold stage is clocked. The hold control and the address are sampled on the rising clock edge. The path from the address, the enables and the held value to the outputs is purely combinational.

Top module: `latched_decoder`

## Requirements
- R1: In the first cycle in which `latch_en_i` is high after a cycle in which it was low (or after reset), the address on `addr_i` in that cycle is captured, and that same cycle's outputs already decode it.
- R2: While `latch_en_i` stays high on consecutive cycles, changes on `addr_i` have no effect, and the outputs keep decoding the captured address.
- R3: In any cycle in which `latch_en_i` is low, the outputs decode the live `addr_i` in that same cycle (transparent).
- R4: Every bit of `sel_n_o` is 1 unless `en_hi_i` is 1 and `en_lo_n_i` is 0.
- R5: The enables take effect in the same cycle, whatever the state of `latch_en_i` and the address. Disabling and then re-enabling while the address is held restores the selection of the captured address.
- R6: When enabled, exactly one bit of `sel_n_o` is 0, at index `addr[2]*4 + addr[1]*2 + addr[0]`. Bit 2 is the most significant address bit, so address 0 selects bit 0 and address 7 selects bit 7.
- R7: While `rst_n` is low, the hold stage is cleared and treated as open, so the outputs decode the live `addr_i` even if `latch_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the hold stage samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Address; bit 2 is most significant |
| latch_en_i | input | 1 | Hold control: low passes the address through, high holds it |
| en_hi_i | input | 1 | Active-high output enable |
| en_lo_n_i | input | 1 | Active-low output enable |
| sel_n_o | output | 8 | Active-low select lines, at most one low |

## Verification
A corrupted held address shows up only once the hold control has been high for a second cycle. From that cycle on, the wrong line stays low for the whole hold, whatever the address pins do, so the bench changes the address during every hold to expose it. A hold-tracking flop stuck at either value shows up in the same cycle: either the outputs follow address changes that should be ignored, or a fresh capture decodes a stale value. Enable-gating faults show up without delay, because the output path has no register.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  localparam int unsigned DEF_ADDR_W = 3;

  // Outputs are live only for the enable combination high / low.
  function automatic logic outputs_enabled(input logic en_hi, input logic en_lo_n);
    return en_hi & ~en_lo_n;
  endfunction
endpackage

// File: rtl/latdec_hold.sv
module latdec_hold #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              latch_en_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic              le_q;
  logic [ADDR_W-1:0] held_q;
  logic [ADDR_W-1:0] held_d;
  logic              holding;

  // Holding only once the control has been high for a prior cycle.
  always_comb begin
    holding    = latch_en_i & le_q;
    eff_addr_o = holding ? held_q : addr_i;
    held_d     = eff_addr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q   <= 1'b0;
      held_q <= '0;
    end else begin
      le_q   <= latch_en_i;
      held_q <= held_d;
    end
  end

  a_r1_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en_i && !le_q) |=> (held_q == $past(addr_i)));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en_i && le_q) |=> (held_q == $past(held_q)));
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_N-1:0]  hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/latdec_gate.sv
module latdec_gate #(
  parameter int unsigned OUT_N = 1 << latdec_pkg::DEF_ADDR_W
) (
  input  logic [OUT_N-1:0] hot_i,
  input  logic             en_hi_i,
  input  logic             en_lo_n_i,
  output logic [OUT_N-1:0] sel_n_o
);
  always_comb begin
    if (latdec_pkg::outputs_enabled(en_hi_i, en_lo_n_i)) sel_n_o = ~hot_i;
    else                                                  sel_n_o = '1;
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              latch_en_i,
  input  logic              en_hi_i,
  input  logic              en_lo_n_i,
  output logic [OUT_N-1:0]  sel_n_o
);
  logic [ADDR_W-1:0] eff_addr;
  logic [OUT_N-1:0]  hot;

  latdec_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .latch_en_i (latch_en_i),
    .eff_addr_o (eff_addr)
  );

  latdec_onehot #(.ADDR_W(ADDR_W)) u_onehot (
    .addr_i (eff_addr),
    .hot_o  (hot)
  );

  latdec_gate #(.OUT_N(OUT_N)) u_gate (
    .hot_i     (hot),
    .en_hi_i   (en_hi_i),
    .en_lo_n_i (en_lo_n_i),
    .sel_n_o   (sel_n_o)
  );

  a_r4_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_hi_i && !en_lo_n_i) |-> (sel_n_o == '1));

  a_r6_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi_i && !en_lo_n_i) |-> ($countones(~sel_n_o) == 1));

  a_r3_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en_i && en_hi_i && !en_lo_n_i) |-> !sel_n_o[addr_i]);
endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;
  localparam int ADDR_W = 3;
  localparam int OUT_N  = 8;

  typedef struct {
    logic [OUT_N-1:0] exp;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [ADDR_W-1:0] addr;
  logic             le, g_hi, g_lo_n;
  logic [OUT_N-1:0] sel_n;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  // Bench model of the hold stage, written from the requirements.
  bit              m_leq  = 0;
  bit [ADDR_W-1:0] m_held = '0;

  always #2 clk = ~clk;

  latched_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr),
    .latch_en_i (le),
    .en_hi_i    (g_hi),
    .en_lo_n_i  (g_lo_n),
    .sel_n_o    (sel_n)
  );

  task automatic drive(input bit r, input bit [2:0] a, input bit l,
                       input bit h, input bit ln, input string tag);
    bit [2:0] eff;
    item_t it;
    @(posedge clk);
    #1;
    rst_n = r; addr = a; le = l; g_hi = h; g_lo_n = ln;
    if (!r) begin
      eff = a;                            // R7: open during reset
      m_leq = 0; m_held = '0;
    end else begin
      eff = (l && m_leq) ? m_held : a;    // R1/R2/R3
      m_held = eff; m_leq = l;
    end
    it.exp = (h && !ln) ? ~(8'b1 << eff) : 8'hFF;   // R4/R6
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares away from the active edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (sel_n !== it.exp) begin
          n_fail++;
          $display("FAIL %s: sel_n=%b expected %b", it.tag, sel_n, it.exp);
        end
      end
    end
  end

  initial begin
    rst_n = 0; addr = 0; le = 0; g_hi = 0; g_lo_n = 1;
    // R7: reset state, hold control high but live address decoded
    drive(0, 3'd5, 1, 1, 0, "R7 reset transparent");
    drive(0, 3'd2, 1, 0, 0, "R7 R4 reset disabled");
    drive(0, 3'd6, 1, 1, 0, "R7 reset live addr");
    // R1: first cycle after reset with control high captures
    drive(1, 3'd3, 1, 1, 0, "R1 capture after reset");
    drive(1, 3'd0, 1, 1, 0, "R2 hold after reset");
    // R3 R4 R6: transparent sweep over all enable combinations
    for (int e = 0; e < 4; e++)
      for (int a = 0; a < 8; a++)
        drive(1, 3'(a), 0, e[1], e[0], "R3 R4 R6 transparent sweep");
    // R1 R2 R5: capture on rise, ignore changes, enable toggling
    for (int a = 0; a < 8; a++) begin
      drive(1, 3'(a + 3), 0, 1, 0, "R3 before rise");
      drive(1, 3'(a), 1, 1, 0, "R1 capture on rise");
      for (int b = 0; b < 8; b++)
        drive(1, 3'(b), 1, (b % 4) != 1, (b % 4) == 2, "R2 R5 held sweep");
      drive(1, 3'(a + 5), 1, 1, 0, "R5 reenable restores held");
      drive(1, 3'(a + 1), 0, 1, 0, "R3 reopen follows addr");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule